// File: doc/BRIEF.md
# Status-coded I2C byte master

This block is an I2C bus master that a processor steps one bus phase at a time through four byte-wide registers: control, data, status, and a soft-reset strobe. Software requests a start or stop condition, or the acknowledge it wants to return, by setting bits in the control register. It places an address byte or a data byte in the data register. Each phase begins when software clears the interrupt flag in the control register.

When a phase ends, the engine writes an 8-bit code into the status register and raises the flag again. The phases are a start, a repeated start, an address byte, a data byte sent or received, a stop, and a lost arbitration. While the flag is up and the engine owns the bus, it holds SCL low, so the bus waits for software. SCL and SDA are open-drain: the block has one pull-low enable per line and reads the real line levels back. Bit timing comes from a one-cycle quarter-bit tick supplied by a separate baud generator. A bit takes four ticks, and the engine waits for SCL to read high, so a slave can stretch the clock.

Register map (regAddr): 0 control, 1 data, 2 status (read only), 3 soft reset (any write).

Top module: `i2c_step_master`

## Requirements
- R1: After rstN, or after any write to register 3, status reads 0xF8, control reads 0x00, and both line pull-downs (sclOeLow, sdaOeLow) are off.
- R2: Control bits are ACK=2, flag=3, STOP=4, START=5, bus enable=6, interrupt enable=7. Set START with enable on and the flag clear, from idle. The engine sends a start condition, clears START by itself, posts status 0x08 and raises the flag.
- R3: While the flag is set and the engine owns the bus, SCL is held low and the status does not change. A control write can only clear the flag (write 0 to bit 3) and never sets it.
- R4: An address phase sends the data register MSB first: the 7-bit address is in bits [7:1], and bit 0 selects the direction (0 write, 1 read). An acknowledged address gives 0x18 (write) or 0x40 (read). A refused address gives 0x20 (write) or 0x48 (read).
- R5: A transmitted data byte goes out MSB first and gives status 0x28 when acknowledged and 0x30 when refused.
- R6: In a read, each received byte lands in the data register. With ACK=1 the engine pulls SDA low in the acknowledge bit and posts 0x50. With ACK=0 it leaves SDA released (NAK) and posts 0x58.
- R7: If START is set in the same control write that clears the flag, during a transfer, the engine sends a repeated start and posts 0x10.
- R8: If the engine releases SDA on an address or data bit and reads it low, it posts 0x38. It then raises the flag and releases both lines.
- R9: Setting STOP together with the flag clear sends a stop condition. STOP then clears by itself, the status returns to 0xF8, and the flag stays clear.
- R10: A START request while bus enable is 0 sends nothing, and the status stays 0xF8.
- R11: After releasing SCL within a bit, the engine does not go on until SCL reads high. A slave holding SCL low therefore delays the end of the phase.
- R12: irq is high exactly when the flag and interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| sclTick | input | 1 | One-cycle quarter-bit tick from the baud generator |
| sclIn | input | 1 | Sensed SCL level |
| sdaIn | input | 1 | Sensed SDA level |
| sclOeLow | output | 1 | Pull SCL low when 1 |
| sdaOeLow | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties rely on disciplined software. Software writes the data register only while the flag is up. It never requests START and STOP in the same write. It never writes control in the cycle in which the engine retires a START. They also assume that sclTick is a single-cycle pulse spaced several clocks apart. The stimulus follows these rules: every register access happens through bench tasks that first wait for the flag, or for STOP to fall, before the next write. The slave model, the rival master that pulls SDA low, and the clock-stretcher drive the lines only while SCL is low, except for genuine start and stop conditions.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;
  localparam int REG_W = 8;

  // control bit positions
  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  // status codes
  localparam logic [REG_W-1:0] CODE_START   = 8'h08;
  localparam logic [REG_W-1:0] CODE_RSTART  = 8'h10;
  localparam logic [REG_W-1:0] CODE_AW_ACK  = 8'h18;
  localparam logic [REG_W-1:0] CODE_AW_NAK  = 8'h20;
  localparam logic [REG_W-1:0] CODE_DW_ACK  = 8'h28;
  localparam logic [REG_W-1:0] CODE_DW_NAK  = 8'h30;
  localparam logic [REG_W-1:0] CODE_ARB     = 8'h38;
  localparam logic [REG_W-1:0] CODE_AR_ACK  = 8'h40;
  localparam logic [REG_W-1:0] CODE_AR_NAK  = 8'h48;
  localparam logic [REG_W-1:0] CODE_DR_ACK  = 8'h50;
  localparam logic [REG_W-1:0] CODE_DR_NAK  = 8'h58;
  localparam logic [REG_W-1:0] CODE_IDLE    = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_RSTART, ST_BIT, ST_STOP
  } engState_t;

  typedef struct packed {
    logic             post;
    logic             raiseFlag;
    logic [REG_W-1:0] code;
    logic             shiftIn;
    logic             clrStart;
    logic             clrStop;
  } engStrobe_t;
endpackage

// File: rtl/i2c_step_dp.sv
module i2c_step_dp
  import i2c_step_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic [REG_W-1:0]  wrData,
  input  engStrobe_t        evt,
  input  logic              sdaIn,
  output logic [REG_W-1:0]  ctrlReg,
  output logic [DATA_W-1:0] dataReg,
  output logic [REG_W-1:0]  statusReg
);
  logic [REG_W-1:0] ctrlNext;

  always_comb begin
    ctrlNext = ctrlReg;
    if (ctrlWr) begin
      ctrlNext[CB_IEN]   = wrData[CB_IEN];
      ctrlNext[CB_EN]    = wrData[CB_EN];
      ctrlNext[CB_ACK]   = wrData[CB_ACK];
      ctrlNext[CB_START] = ctrlReg[CB_START] | wrData[CB_START];
      ctrlNext[CB_STOP]  = ctrlReg[CB_STOP] | wrData[CB_STOP];
      ctrlNext[CB_FLAG]  = ctrlReg[CB_FLAG] & wrData[CB_FLAG];
    end
    if (evt.clrStart)  ctrlNext[CB_START] = 1'b0;
    if (evt.clrStop)   ctrlNext[CB_STOP]  = 1'b0;
    if (evt.raiseFlag) ctrlNext[CB_FLAG]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      dataReg   <= '0;
      statusReg <= CODE_IDLE;
    end else if (softRst) begin
      ctrlReg   <= '0;
      dataReg   <= '0;
      statusReg <= CODE_IDLE;
    end else begin
      ctrlReg <= ctrlNext;
      if (dataWr)
        dataReg <= wrData[DATA_W-1:0];
      else if (evt.shiftIn)
        dataReg <= {dataReg[DATA_W-2:0], sdaIn};
      if (evt.post)
        statusReg <= evt.code;
    end
  end

  // the flag can only rise because the engine finished a phase
  p_flag_source_r3: assert property (@(posedge clk) disable iff (!rstN || softRst)
    $rose(ctrlReg[CB_FLAG]) |-> $past(evt.raiseFlag));

  // a retired START is gone on the next cycle
  p_start_selfclear_r2: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (evt.clrStart && !ctrlWr) |=> !ctrlReg[CB_START]);
endmodule

// File: rtl/i2c_step_ctrl.sv
module i2c_step_ctrl
  import i2c_step_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       sclTick,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       busEn,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       ackEn,
  input  logic       iflg,
  input  logic       txBit,
  input  logic       rwBit,
  output engStrobe_t evt,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       holdState
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  engState_t state, stateN;
  logic [1:0] q, qN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic addrPhase, addrN, rdMode, rdN, ackSeen, ackN, sclN, sdaN;
  logic txPhase;
  logic [REG_W-1:0] doneCode;

  assign txPhase   = addrPhase | !rdMode;
  assign holdState = (state == ST_HOLD);

  always_comb begin
    if (addrPhase)
      doneCode = rwBit ? (ackSeen ? CODE_AR_ACK : CODE_AR_NAK)
                       : (ackSeen ? CODE_AW_ACK : CODE_AW_NAK);
    else if (!rdMode)
      doneCode = ackSeen ? CODE_DW_ACK : CODE_DW_NAK;
    else
      doneCode = sdaLow ? CODE_DR_ACK : CODE_DR_NAK;
  end

  always_comb begin
    stateN = state; qN = q; cntN = bitCnt; addrN = addrPhase; rdN = rdMode;
    ackN = ackSeen; sclN = sclLow; sdaN = sdaLow;
    evt = '0;
    if (sclTick) begin
      case (state)
        ST_IDLE: begin
          if (stopReq) begin
            evt.clrStop = 1'b1; evt.post = 1'b1; evt.code = CODE_IDLE;
          end else if (busEn && startReq && !iflg) begin
            stateN = ST_START; qN = 2'd0;
          end
        end
        ST_START: begin
          if (q == 2'd0) begin
            sdaN = 1'b1; qN = 2'd1;
          end else begin
            sclN = 1'b1; stateN = ST_HOLD; addrN = 1'b1;
            evt.post = 1'b1; evt.raiseFlag = 1'b1; evt.clrStart = 1'b1;
            evt.code = CODE_START;
          end
        end
        ST_HOLD: begin
          if (!iflg) begin
            qN = 2'd0;
            if (startReq)     stateN = ST_RSTART;
            else if (stopReq) stateN = ST_STOP;
            else begin        stateN = ST_BIT; cntN = '0; end
          end
        end
        ST_RSTART: begin
          qN = q + 2'd1;
          case (q)
            2'd0: sdaN = 1'b0;
            2'd1: sclN = 1'b0;
            2'd2: sdaN = 1'b1;
            default: begin
              sclN = 1'b1; stateN = ST_HOLD; addrN = 1'b1;
              evt.post = 1'b1; evt.raiseFlag = 1'b1; evt.clrStart = 1'b1;
              evt.code = CODE_RSTART;
            end
          endcase
        end
        ST_STOP: begin
          case (q)
            2'd0: begin sdaN = 1'b1; qN = 2'd1; end
            2'd1: begin sclN = 1'b0; qN = 2'd2; end
            default: if (sclIn) begin
              sdaN = 1'b0; stateN = ST_IDLE; qN = 2'd0;
              evt.clrStop = 1'b1; evt.post = 1'b1; evt.code = CODE_IDLE;
            end
          endcase
        end
        ST_BIT: begin
          case (q)
            2'd0: begin
              sdaN = (bitCnt == LAST) ? (!txPhase && ackEn) : (txPhase && !txBit);
              qN = 2'd1;
            end
            2'd1: begin sclN = 1'b0; qN = 2'd2; end
            2'd2: if (sclIn) begin
              qN = 2'd3;
              if (bitCnt != LAST) begin
                evt.shiftIn = 1'b1;
                if (txPhase && !sdaLow && !sdaIn) begin
                  stateN = ST_IDLE; qN = 2'd0; sclN = 1'b0; sdaN = 1'b0;
                  evt.post = 1'b1; evt.raiseFlag = 1'b1; evt.code = CODE_ARB;
                end
              end else
                ackN = !sdaIn;
            end
            default: begin
              sclN = 1'b1; qN = 2'd0;
              if (bitCnt == LAST) begin
                stateN = ST_HOLD; addrN = 1'b0;
                if (addrPhase) rdN = rwBit;
                evt.post = 1'b1; evt.raiseFlag = 1'b1; evt.code = doneCode;
              end else
                cntN = bitCnt + CNT_W'(1);
            end
          endcase
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; q <= '0; bitCnt <= '0; addrPhase <= 1'b0;
      rdMode <= 1'b0; ackSeen <= 1'b0; sclLow <= 1'b0; sdaLow <= 1'b0;
    end else if (softRst) begin
      state <= ST_IDLE; q <= '0; bitCnt <= '0; addrPhase <= 1'b0;
      rdMode <= 1'b0; ackSeen <= 1'b0; sclLow <= 1'b0; sdaLow <= 1'b0;
    end else begin
      state <= stateN; q <= qN; bitCnt <= cntN; addrPhase <= addrN;
      rdMode <= rdN; ackSeen <= ackN; sclLow <= sclN; sdaLow <= sdaN;
    end
  end

  // SDA only moves under a low SCL while bits are shifting
  p_sda_under_low_scl_r4: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (state == ST_BIT && $past(state) == ST_BIT && !$stable(sdaLow)) |-> $past(sclLow));

  // losing the bus lets go of both lines
  p_arb_release_r8: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (evt.post && evt.code == CODE_ARB) |=> (!sclLow && !sdaLow && state == ST_IDLE));

  // an idle engine never pulls a line
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (state == ST_IDLE) |-> (!sclLow && !sdaLow));
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2c_step_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             sclTick,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOeLow,
  output logic             sdaOeLow,
  output logic             irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_SRST = 2'd3;

  logic [REG_W-1:0]  ctrlReg, statusReg;
  logic [DATA_W-1:0] dataReg;
  engStrobe_t        evt;
  logic              ctrlWr, dataWr, softRst, holdState;

  assign ctrlWr  = regWrEn && (regAddr == A_CTRL);
  assign dataWr  = regWrEn && (regAddr == A_DATA);
  assign softRst = regWrEn && (regAddr == A_SRST);

  i2c_step_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .ctrlWr(ctrlWr), .dataWr(dataWr),
    .wrData(regWrData), .evt(evt), .sdaIn(sdaIn),
    .ctrlReg(ctrlReg), .dataReg(dataReg), .statusReg(statusReg)
  );

  i2c_step_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .sclTick(sclTick),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .busEn(ctrlReg[CB_EN]), .startReq(ctrlReg[CB_START]), .stopReq(ctrlReg[CB_STOP]),
    .ackEn(ctrlReg[CB_ACK]), .iflg(ctrlReg[CB_FLAG]),
    .txBit(dataReg[DATA_W-1]), .rwBit(dataReg[0]),
    .evt(evt), .sclLow(sclOeLow), .sdaLow(sdaOeLow), .holdState(holdState)
  );

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = ctrlReg;
      A_DATA:  regRdData = REG_W'(dataReg);
      A_STAT:  regRdData = statusReg;
      default: regRdData = '0;
    endcase
  end

  assign irq = ctrlReg[CB_IEN] & ctrlReg[CB_FLAG];

  // a pending flag on an owned bus stalls it with SCL low
  p_hold_stalls_r3: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (ctrlReg[CB_FLAG] && holdState) |-> sclOeLow);

  // the status is frozen while software owes a response
  p_status_frozen_r3: assert property (@(posedge clk) disable iff (!rstN || softRst)
    ($past(ctrlReg[CB_FLAG]) && ctrlReg[CB_FLAG] && $past(holdState)) |-> $stable(statusReg));
endmodule

// File: tb/i2c_step_master_tb_top.sv
module i2c_step_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV = 7'h2A;
  localparam logic [7:0] M_ACK = 8'h04, M_FLAG = 8'h08, M_STOP = 8'h10,
                         M_START = 8'h20, M_EN = 8'h40, M_IEN = 8'h80;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0, regRdData;
  logic sclOeLow, sdaOeLow, irq;
  logic [1:0] tickCnt = 2'd0;
  logic sclTick;
  logic rivalLow = 1'b0, stretch = 1'b0, slvSdaLow = 1'b0;
  wire sclBus = !(sclOeLow || stretch);
  wire sdaBus = !(sdaOeLow || slvSdaLow || rivalLow);

  int nVec = 0, nBad = 0;
  bit finished = 1'b0;
  logic [7:0] cb;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) tickCnt <= tickCnt + 2'd1;
  assign sclTick = (tickCnt == 2'd3);

  i2c_step_master dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclTick(sclTick),
    .sclIn(sclBus), .sdaIn(sdaBus), .sclOeLow(sclOeLow), .sdaOeLow(sdaOeLow), .irq(irq)
  );

  // ---------------- slave model ----------------
  int pos = 0, rdIdx = 0, wrCount = 0, wrLimit = 8;
  bit active = 0, addrPh = 0, matched = 0, rdM = 0, mAck = 0, sawNak = 0;
  logic [7:0] rx = 8'd0, tx = 8'd0, lastWr = 8'd0;

  function automatic logic [7:0] rdByte(input int i);
    return 8'hC3 ^ (8'(i) * 8'h29);
  endfunction

  always @(negedge sdaBus) if (sclBus === 1'b1) begin
    pos = 0; addrPh = 1; active = 1; slvSdaLow = 1'b0;
  end
  always @(posedge sdaBus) if (sclBus === 1'b1) begin
    active = 0; slvSdaLow = 1'b0;
  end
  always @(posedge sclBus) if (active) begin
    if (pos < 8) rx = {rx[6:0], sdaBus};
    else if (pos == 8 && rdM && !addrPh) begin
      mAck = !sdaBus;
      if (!mAck) sawNak = 1;
    end
    pos++;
  end
  always @(negedge sclBus) if (active) begin
    if (pos == 8) begin
      if (addrPh) begin
        matched = (rx[7:1] == SLV); rdM = rx[0]; slvSdaLow = matched;
        if (matched && !rdM) wrCount = 0;
      end else if (!rdM) begin
        lastWr = rx; slvSdaLow = (wrCount < wrLimit); wrCount++;
      end else slvSdaLow = 1'b0;
    end else if (pos == 9) begin
      pos = 0; slvSdaLow = 1'b0;
      if (addrPh) begin
        addrPh = 0;
        if (!matched) active = 0;
        else if (rdM) begin rdIdx = 0; tx = rdByte(0); slvSdaLow = !tx[7]; end
      end else if (rdM && mAck) begin
        rdIdx++; tx = rdByte(rdIdx); slvSdaLow = !tx[7];
      end
    end else if (pos >= 1 && pos <= 7 && !addrPh && rdM && matched)
      slvSdaLow = !tx[7-pos];
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1; v = regRdData;
  endtask

  task automatic waitFlag(input string req);
    logic [7:0] v;
    bit seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      rd(2'd0, v);
      if (v[3]) seen = 1;
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic expectStatus(input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(2'd2, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic doStart(input bit rep);
    logic [7:0] v;
    wr(2'd0, cb | M_START);
    waitFlag(rep ? "R7 flag" : "R2 flag");
    expectStatus(rep ? 8'h10 : 8'h08, rep ? "R7 status" : "R2 status");
    rd(2'd0, v);
    chk(v[5] == 1'b0, "R2 start self-clear", v, v & ~M_START);
    chk(sclOeLow == 1'b1, "R3 scl held", sclOeLow, 1);
    chk(irq == cb[7], "R12 irq", irq, cb[7]);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic [7:0] exp, input string req);
    wr(2'd1, b);
    wr(2'd0, cb);
    waitFlag(req);
    expectStatus(exp, req);
  endtask

  task automatic doStop();
    logic [7:0] v;
    bit done = 0;
    wr(2'd0, cb | M_STOP);
    for (int k = 0; k < 3000 && !done; k++) begin
      rd(2'd0, v);
      if (!v[4]) done = 1;
    end
    chk(done, "R9 stop self-clear", 0, 1);
    expectStatus(8'hF8, "R9 idle code");
    rd(2'd0, v);
    chk(v[3] == 1'b0, "R9 flag stays clear", v, v & ~M_FLAG);
    chk(!sclOeLow && !sdaOeLow, "R9 lines released", {sclOeLow, sdaOeLow}, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic writeTxn(input logic [6:0] a, input int nb, input int lim, input logic [7:0] seed);
    wrLimit = lim;
    doStart(0);
    sendByte({a, 1'b0}, (a == SLV) ? 8'h18 : 8'h20, "R4 write address");
    if (a == SLV) begin
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b;
        b = seed + 8'(i) * 8'h4D;
        sendByte(b, (i < lim) ? 8'h28 : 8'h30, "R5 data byte");
        chk(lastWr == b, "R5 byte on bus", lastWr, b);
      end
    end
    doStop();
  endtask

  task automatic readTxn(input int nb);
    logic [7:0] v;
    wrLimit = 8; sawNak = 0;
    doStart(0);
    sendByte({SLV, 1'b0}, 8'h18, "R4 write address");
    sendByte(8'h00, 8'h28, "R5 offset byte");
    wr(2'd0, cb | M_START);
    waitFlag("R7 flag");
    expectStatus(8'h10, "R7 repeated start");
    sendByte({SLV, 1'b1}, 8'h40, "R4 read address");
    for (int i = 0; i < nb; i++) begin
      bit last;
      last = (i == nb - 1);
      wr(2'd0, last ? (cb & ~M_ACK) : cb);
      waitFlag("R6 flag");
      expectStatus(last ? 8'h58 : 8'h50, "R6 receive status");
      rd(2'd1, v);
      chk(v == rdByte(i), "R6 received byte", v, rdByte(i));
    end
    chk(sawNak == 1'b1, "R6 NAK on bus", sawNak, 1);
    doStop();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] v;
    cb = M_EN | M_IEN | M_ACK;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    expectStatus(8'hF8, "R1 reset status");
    rd(2'd0, v); chk(v == 8'h00, "R1 reset control", v, 0);
    chk(!sclOeLow && !sdaOeLow, "R1 lines released", {sclOeLow, sdaOeLow}, 0);
    chk(irq == 1'b0, "R12 irq idle", irq, 0);

    // R3 a control write cannot raise the flag
    wr(2'd0, M_EN | M_FLAG);
    rd(2'd0, v); chk(v == M_EN, "R3 flag not settable", v, M_EN);
    wr(2'd0, 8'h00);

    // R10 start without enable
    wr(2'd0, M_START);
    repeat (200) @(negedge clk);
    expectStatus(8'hF8, "R10 no start");
    chk(!sclOeLow && !sdaOeLow, "R10 lines idle", {sclOeLow, sdaOeLow}, 0);
    wr(2'd3, 8'h00);
    rd(2'd0, v); chk(v == 8'h00, "R1 soft reset control", v, 0);

    // writes: address sweep, byte values, data NAK
    writeTxn(SLV, 3, 8, 8'h11);
    writeTxn(SLV, 3, 2, 8'hF0);
    writeTxn(SLV, 2, 8, 8'h80);
    writeTxn(SLV ^ 7'h05, 1, 8, 8'h00);
    writeTxn(SLV ^ 7'h40, 1, 8, 8'h00);

    // reads of several lengths
    for (int n = 1; n <= 4; n++) readTxn(n);

    // refused read address
    doStart(0);
    sendByte({SLV ^ 7'h01, 1'b1}, 8'h48, "R4 read address NAK");
    doStop();

    // R3 stall while flag set
    doStart(0);
    repeat (200) @(negedge clk);
    chk(sclOeLow == 1'b1, "R3 still holding", sclOeLow, 1);
    expectStatus(8'h08, "R3 status frozen");
    doStop();

    // R8 arbitration loss on an address bit sent high
    doStart(0);
    wr(2'd1, {7'h55, 1'b0});
    rivalLow = 1'b1;
    wr(2'd0, cb);
    waitFlag("R8 flag");
    expectStatus(8'h38, "R8 arbitration code");
    chk(!sclOeLow && !sdaOeLow, "R8 lines released", {sclOeLow, sdaOeLow}, 0);
    rivalLow = 1'b0;
    wr(2'd0, cb);
    repeat (40) @(negedge clk);

    // R11 clock stretching, interrupts masked (R12)
    cb = M_EN | M_ACK;
    wrLimit = 8;
    doStart(0);
    sendByte({SLV, 1'b0}, 8'h18, "R4 write address");
    wr(2'd1, 8'h5A);
    stretch = 1'b1;
    wr(2'd0, cb);
    repeat (300) @(negedge clk);
    rd(2'd0, v); chk(v[3] == 1'b0, "R11 waits on stretched SCL", v[3], 0);
    expectStatus(8'h18, "R11 status unchanged");
    stretch = 1'b0;
    waitFlag("R11 flag");
    expectStatus(8'h28, "R11 byte completes");
    chk(irq == 1'b0, "R12 masked irq", irq, 0);
    doStop();

    // R1 soft reset mid-transfer
    cb = M_EN | M_IEN | M_ACK;
    doStart(0);
    wr(2'd3, 8'h00);
    expectStatus(8'hF8, "R1 soft reset status");
    rd(2'd0, v); chk(v == 8'h00, "R1 soft reset control", v, 0);
    chk(!sclOeLow && !sdaOeLow, "R1 soft reset lines", {sclOeLow, sdaOeLow}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule